// File: doc/BRIEF.md
# Conversion Start Bridge for a Successive-Approximation Converter

This block sits between an 8-bit processor bus and a successive-approximation converter that uses a single blank-and-convert control line and a data-ready status line. A processor write to the data address sets an internal flip-flop. The flip-flop drives the control line high, which blanks the converter. When the converter raises its ready line in reply, the flip-flop clears and the control line drops low. That falling edge starts the conversion. The width of the start pulse therefore comes from the converter's own acknowledgement and not from a timer, so the converter's minimum pulse width is always met.

At rest the control line stays low and the ready line is low. The last result then remains valid at the converter for as long as no new command arrives. A read of the data address places the result on the bus. A read of a second address returns the ready line, so software can poll for completion. All bus strobes and the ready line pass through synchronisers into the system clock. The flip-flop responds only to edges, so a long strobe triggers it once.

Top module: `adc_cmd_bridge`

## Requirements
- R1: While reset is asserted, `cnv_start` is 0, `bus_oe` is 0 and `bus_dout` is 0.
- R2: A write, meaning `bus_csd_n` and `bus_wr_n` both low while the bridge is idle, drives `cnv_start` high within four clocks.
- R3: Once high, `cnv_start` stays high until a rising edge of `cnv_ready` is seen. It then returns low, which starts the conversion.
- R4: After `cnv_ready` falls, a data read returns the converted value. Later reads keep returning it for as long as no new command is issued.
- R5: `bus_oe` is high with `bus_dout` equal to `cnv_data` only while `bus_csd_n` and `bus_rd_n` are both low. Either strobe alone leaves `bus_oe` low.
- R6: A status read, meaning `bus_css_n` and `bus_rd_n` both low, returns `cnv_ready` in bit 0 (1 = busy) and zeros in all other bits.
- R7: With no read active, `bus_oe` is 0 and `bus_dout` is 0. A write while only `bus_css_n` is low does not start a conversion.
- R8: A write that arrives while `cnv_ready` is high or `cnv_start` is high is ignored. A conversion in progress is not disturbed.
- R9: A write strobe held low for longer than a whole conversion produces exactly one start pulse.
- R10: If both select lines are low during a read, the data result is returned and the status word is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_csd_n | input | 1 | Decoded select for the data/command address, active low |
| bus_css_n | input | 1 | Decoded select for the status address, active low |
| bus_wr_n | input | 1 | Bus write strobe, active low |
| bus_rd_n | input | 1 | Bus read strobe, active low |
| bus_dout | output | 8 | Read data toward the bus; zero when not driven |
| bus_oe | output | 1 | Drive enable for the bus buffers |
| cnv_start | output | 1 | Blank-and-convert control to the converter; high blanks, the falling edge starts |
| cnv_ready | input | 1 | Converter data-ready; high while blanked or converting |
| cnv_data | input | 8 | Converter result lines |

## Verification
The bench checks that a start pulse holds for the full wait before the converter acknowledges. A design that timed the pulse itself, or that cleared on the level of the ready line, would drop the control line early. It issues a write in the middle of a conversion. A bridge that accepted it would re-blank the converter, and the conversion would abort with the ready line stuck high. It holds the write strobe low across a whole conversion to catch level triggering, which would restart the converter again and again. It also reads with each strobe alone, with both selects low, and after a long idle gap, to expose a wrong output enable, a wrong priority or a lost result.

// File: rtl/acb_pkg.sv
package acb_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_STAT = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/acb_sync.sv
module acb_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= RST_VAL;
        else        stg <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= {STAGES{RST_VAL}};
        else        stg <= {stg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/acb_cmd_flop.sv
module acb_cmd_flop (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_req,
  input  logic rdy_s,
  output logic start
);
  logic start_q, start_d;
  logic wr_prev_q, rdy_prev_q;
  logic wr_edge, rdy_rise;

  assign wr_edge  = wr_req & ~wr_prev_q;
  assign rdy_rise = rdy_s & ~rdy_prev_q;

  // Set on a write edge only when idle; clear on the converter's acknowledge.
  always_comb begin
    start_d = start_q;
    if (start_q && rdy_rise)
      start_d = 1'b0;
    else if (!start_q && !rdy_s && wr_edge)
      start_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q    <= 1'b0;
      wr_prev_q  <= 1'b0;
      rdy_prev_q <= 1'b0;
    end else begin
      start_q    <= start_d;
      wr_prev_q  <= wr_req;
      rdy_prev_q <= rdy_s;
    end
  end

  assign start = start_q;
endmodule

// File: rtl/acb_rd_mux.sv
module acb_rd_mux
  import acb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_data,
  input  logic              rd_stat,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              rdy,
  output logic              oe,
  output logic [DATA_W-1:0] dout
);
  rd_sel_e            sel;
  logic               oe_d;
  logic [DATA_W-1:0]  dout_d;

  always_comb begin
    if (rd_data)      sel = SEL_DATA;
    else if (rd_stat) sel = SEL_STAT;
    else              sel = SEL_NONE;
  end

  always_comb begin
    oe_d   = 1'b0;
    dout_d = '0;
    case (sel)
      SEL_DATA: begin oe_d = 1'b1; dout_d = conv_data; end
      SEL_STAT: begin oe_d = 1'b1; dout_d = {{(DATA_W-1){1'b0}}, rdy}; end
      default:  begin oe_d = 1'b0; dout_d = '0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe   <= 1'b0;
      dout <= '0;
    end else begin
      oe   <= oe_d;
      dout <= dout_d;
    end
  end
endmodule

// File: rtl/adc_cmd_bridge.sv
module adc_cmd_bridge #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_csd_n,
  input  logic              bus_css_n,
  input  logic              bus_wr_n,
  input  logic              bus_rd_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  output logic              cnv_start,
  input  logic              cnv_ready,
  input  logic [DATA_W-1:0] cnv_data
);
  localparam int NSTB = 4;

  logic [1:0]      rst_pipe;
  logic            rst_i_n;
  logic [NSTB-1:0] stb_s;
  logic            rdy_s;
  logic            csd_s_n, css_s_n, wr_s_n, rd_s_n;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  acb_sync #(.W(NSTB), .STAGES(SYNC_STAGES), .RST_VAL({NSTB{1'b1}})) u_stb_sync (
    .clk(clk), .rst_n(rst_i_n),
    .d({bus_csd_n, bus_css_n, bus_wr_n, bus_rd_n}),
    .q(stb_s)
  );
  assign {csd_s_n, css_s_n, wr_s_n, rd_s_n} = stb_s;

  acb_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rdy_sync (
    .clk(clk), .rst_n(rst_i_n), .d(cnv_ready), .q(rdy_s)
  );

  acb_cmd_flop u_flop (
    .clk(clk), .rst_n(rst_i_n),
    .wr_req(~csd_s_n & ~wr_s_n),
    .rdy_s(rdy_s),
    .start(cnv_start)
  );

  acb_rd_mux #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_i_n),
    .rd_data(~csd_s_n & ~rd_s_n),
    .rd_stat(~css_s_n & ~rd_s_n),
    .conv_data(cnv_data),
    .rdy(rdy_s),
    .oe(bus_oe),
    .dout(bus_dout)
  );
endmodule

// File: rtl/acb_checker.sv
module acb_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnv_start,
  input logic              cnv_ready,
  input logic              bus_oe,
  input logic [DATA_W-1:0] bus_dout,
  input logic              rdy_s
);
  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!cnv_start && !bus_oe && bus_dout == '0); // R1
    end
  end

  AST_START_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_start) |-> $past(cnv_ready)); // R3

  AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_start) |-> !$past(rdy_s)); // R8

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_dout == '0)); // R7

  AST_START_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_start && !cnv_ready && !rdy_s) |=> cnv_start); // R3
endmodule

bind adc_cmd_bridge acb_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnv_start(cnv_start), .cnv_ready(cnv_ready),
  .bus_oe(bus_oe), .bus_dout(bus_dout), .rdy_s(rdy_s)
);

// File: tb/sim_adc_cmd_bridge.sv
module sim_adc_cmd_bridge;
  localparam int DR_DLY = 24;
  localparam int CONV   = 40;
  localparam logic [7:0] VEC [6] = '{8'h00, 8'hFF, 8'h80, 8'h5A, 8'hA5, 8'h01};

  logic clk = 1'b0;
  logic rst_n;
  logic csd_n, css_n, wr_n, rd_n;
  logic [7:0] bus_dout;
  logic bus_oe, cnv_start;
  logic cnv_ready;
  logic [7:0] cnv_data, model_q, model_val;
  int   ph, cnt;
  int   n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  adc_cmd_bridge u0 (
    .clk(clk), .rst_n(rst_n), .bus_csd_n(csd_n), .bus_css_n(css_n),
    .bus_wr_n(wr_n), .bus_rd_n(rd_n), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .cnv_start(cnv_start), .cnv_ready(cnv_ready), .cnv_data(cnv_data)
  );

  // Converter model: 0 idle, 1 waiting to acknowledge, 2 blanked, 3 converting.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnv_ready <= 1'b0; ph <= 0; cnt <= 0; model_q <= 8'h00;
    end else begin
      case (ph)
        0: if (cnv_start) begin ph <= 1; cnt <= 0; end
        1: begin
             cnt <= cnt + 1;
             if (cnt == DR_DLY) begin cnv_ready <= 1'b1; ph <= 2; end
           end
        2: if (!cnv_start) begin ph <= 3; cnt <= 0; end
        default: begin
             if (cnv_start) ph <= 2;
             else begin
               cnt <= cnt + 1;
               if (cnt == CONV) begin
                 cnv_ready <= 1'b0; model_q <= model_val; ph <= 0;
               end
             end
           end
      endcase
    end
  end
  assign cnv_data = cnv_ready ? 8'h00 : model_q;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input bit to_stat);
    @(negedge clk);
    if (to_stat) css_n = 1'b0; else csd_n = 1'b0;
    wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1; csd_n = 1'b1; css_n = 1'b1;
  endtask

  task automatic do_read(input bit d, input bit s, output logic oe, output logic [7:0] v);
    @(negedge clk);
    csd_n = !d; css_n = !s; rd_n = 1'b0;
    repeat (5) @(negedge clk);
    oe = bus_oe; v = bus_dout;
    rd_n = 1'b1; csd_n = 1'b1; css_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic wait_done;
    wait (cnv_ready === 1'b1);
    wait (cnv_ready === 1'b0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic oe;
    logic [7:0] v;
    csd_n = 1'b1; css_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    model_val = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 start", {7'b0, cnv_start}, 8'h00);
    chk("R1 oe", {7'b0, bus_oe}, 8'h00);
    chk("R1 dout", bus_dout, 8'h00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Vector table walk: convert, read result, read idle status.
    foreach (VEC[i]) begin
      model_val = VEC[i];
      do_write(1'b0);
      wait_done();
      do_read(1'b1, 1'b0, oe, v);
      chk("R5 data oe", {7'b0, oe}, 8'h01);
      chk("R4 data", v, VEC[i]);
      do_read(1'b0, 1'b1, oe, v);
      chk("R6 status idle", v, 8'h00);
      chk("R7 idle oe", {7'b0, bus_oe}, 8'h00);
    end

    // R2 / R3: pulse held until the acknowledge, status busy during conversion.
    model_val = 8'h77;
    do_write(1'b0);
    repeat (2) @(negedge clk);
    chk("R2 start high", {7'b0, cnv_start}, 8'h01);
    repeat (10) @(negedge clk);
    chk("R3 held before ack", {7'b0, cnv_start}, 8'h01);
    wait (cnv_ready === 1'b1);
    repeat (5) @(negedge clk);
    chk("R3 released after ack", {7'b0, cnv_start}, 8'h00);
    do_read(1'b0, 1'b1, oe, v);
    chk("R6 status busy", v, 8'h01);
    wait (cnv_ready === 1'b0);
    repeat (4) @(negedge clk);
    do_read(1'b1, 1'b0, oe, v);
    chk("R4 data 77", v, 8'h77);

    // R8: write during conversion is ignored.
    model_val = 8'h3C;
    do_write(1'b0);
    wait (cnv_ready === 1'b1);
    wait (cnv_start === 1'b0);
    repeat (3) @(negedge clk);
    do_write(1'b0);
    repeat (4) @(negedge clk);
    chk("R8 no restart", {7'b0, cnv_start}, 8'h00);
    wait (cnv_ready === 1'b0);
    repeat (4) @(negedge clk);
    do_read(1'b1, 1'b0, oe, v);
    chk("R8 result intact", v, 8'h3C);

    // R9: held write gives one pulse.
    model_val = 8'hC3;
    @(negedge clk);
    csd_n = 1'b0; wr_n = 1'b0;
    wait_done();
    repeat (20) @(negedge clk);
    chk("R9 no retrigger", {7'b0, cnv_start}, 8'h00);
    chk("R9 ready low", {7'b0, cnv_ready}, 8'h00);
    wr_n = 1'b1; csd_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R9 release quiet", {7'b0, cnv_start}, 8'h00);
    do_read(1'b1, 1'b0, oe, v);
    chk("R9 data", v, 8'hC3);

    // R7: write to the status address does nothing.
    do_write(1'b1);
    repeat (6) @(negedge clk);
    chk("R7 stat write ignored", {7'b0, cnv_start}, 8'h00);

    // R5: single strobes leave the bus undriven.
    @(negedge clk); rd_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R5 rd only oe", {7'b0, bus_oe}, 8'h00);
    rd_n = 1'b1; csd_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R5 cs only oe", {7'b0, bus_oe}, 8'h00);
    chk("R7 cs only dout", bus_dout, 8'h00);
    csd_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: both selects, data wins.
    do_read(1'b1, 1'b1, oe, v);
    chk("R10 priority", v, 8'hC3);

    // R4: result persists over a long idle gap.
    repeat (2000) @(negedge clk);
    do_read(1'b1, 1'b0, oe, v);
    chk("R4 persists", v, 8'hC3);

    // R1: reset mid-operation.
    do_write(1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 start in reset", {7'b0, cnv_start}, 8'h00);
    chk("R1 oe in reset", {7'b0, bus_oe}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule